// File: doc/BRIEF.md
# Transmit Source Address Inserter

This block sits in a 4-bit transmit nibble stream. Software supplies a frame that begins with the 6-byte destination address and continues straight into the EtherType and payload. The block sends the same frame with the 48-bit station address placed directly after the destination address, so the software does not have to write its own address into every frame. When insertion is turned off, the frame goes through unchanged, and the source address is expected to be in the frame already.

The stream moves forward only on clock cycles where the strobe `ce` is high. The output is registered, so each output nibble appears one strobe after the input nibble it follows. In insertion mode the first 12 nibbles go straight through. The 12 address nibbles come next. While they are sent, the incoming data is held in a 12-stage delay line, so the output stays unbroken and is exactly 12 nibbles longer than the input. A cancel input drops the frame in progress. After a cancel the block ignores the input until the input valid has gone low.

Top module: `src_addr_inserter`

## Requirements
- R1: While `rst_n` is low, `out_vld` is low on the next clock edge and stays low.
- R2: When `ins_en` is low at the first valid nibble of a frame, the output frame equals the input frame nibble for nibble, with the same length, delayed by one strobe.
- R3: When `ins_en` is high at the first valid nibble, output nibbles 0 to 11 equal input nibbles 0 to 11, which are the destination address.
- R4: In insertion mode, output nibbles 12 to 23 carry the station address. Its bytes go out from bits 47:40 down to bits 7:0. Within each byte the nibble from bits 3:0 of that byte goes first.
- R5: In insertion mode, output nibbles from 24 onward are input nibbles 12 and later, in the same order. `out_vld` stays high without a break, and the frame is 12 nibbles longer than the input.
- R6: Outputs change only on edges where `ce` is high, except for a cancel or a reset.
- R7: `ins_en` is read only at the start of a frame. A change during a frame has no effect on that frame.
- R8: The station address is captured at the start of a frame. A change during the frame has no effect on the nibbles that are inserted.
- R9: A `cancel` acts on any clock edge, whatever `ce` is. It drives `out_vld` low on the next edge. Input nibbles are then ignored until `in_vld` is seen low on a strobe, and the next frame after that is handled normally.
- R10: An insertion-mode frame shorter than 12 nibbles is passed through unchanged, and no address is added.
- R11: An insertion-mode frame of exactly 12 nibbles produces 24 output nibbles: the destination address followed by the station address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| ce | input | 1 | Strobe; the stream moves forward on cycles where it is high |
| ins_en | input | 1 | Inserts the station address when high at the start of a frame |
| cancel | input | 1 | Drops the frame in progress |
| station_addr | input | 48 | Station address; bits 47:40 are sent first |
| in_vld | input | 1 | Input nibble valid |
| in_nib | input | 4 | Input nibble |
| out_vld | output | 1 | Output nibble valid |
| out_nib | output | 4 | Output nibble |

## Verification
The assertions assume that `in_vld` changes only on strobe cycles. They also assume that, in insertion mode, each frame is followed by at least 12 strobes with `in_vld` low, so the delay line can empty before the next frame starts. `ce` must be driven to a known value from time zero. The stimulus changes inputs only on the falling edge right after a strobe, and sends 30 idle strobes after every frame. It never raises `ce` during a cancel-only cycle except as part of the cancel scenario.

// File: rtl/sa_ins_pkg.sv
// Shared types for the source address inserter.
// Assumes: none; contains only the control state encoding.
package sa_ins_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,  // waiting for a frame
        ST_PASS  = 3'd1,  // insertion off: forward the frame
        ST_DEST  = 3'd2,  // forward the destination address nibbles
        ST_SRC   = 3'd3,  // send the station address nibbles
        ST_BODY  = 3'd4,  // send the delayed rest of the frame
        ST_ABORT = 3'd5   // after a cancel: wait for the input to go idle
    } ins_state_t;

endpackage

// File: rtl/sa_ins_delay.sv
// Delay line of DEPTH stages for valid and nibble, shifted on each strobe.
// Assumes: flush clears only the valid bits; the data bits are don't-care.
module sa_ins_delay #(
    parameter int NIB_W = 4,
    parameter int DEPTH = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ce,
    input  logic             flush,
    input  logic             d_vld,
    input  logic [NIB_W-1:0] d_nib,
    output logic             q_vld,
    output logic [NIB_W-1:0] q_nib
);

    logic [DEPTH-1:0] vld_sr;
    logic [NIB_W-1:0] nib_sr [DEPTH];

    // Stage 0 takes the input
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            vld_sr[0] <= 1'b0;
        end else if (ce) begin
            vld_sr[0] <= d_vld;
        end
    end

    always_ff @(posedge clk) begin
        if (ce) begin
            nib_sr[0] <= d_nib;
        end
    end

    // Every later stage takes the value of the stage before it
    for (genvar g = 1; g < DEPTH; g++) begin : g_stage
        always_ff @(posedge clk) begin
            if (!rst_n || flush) begin
                vld_sr[g] <= 1'b0;
            end else if (ce) begin
                vld_sr[g] <= vld_sr[g-1];
            end
        end

        always_ff @(posedge clk) begin
            if (ce) begin
                nib_sr[g] <= nib_sr[g-1];
            end
        end
    end

    assign q_vld = vld_sr[DEPTH-1];
    assign q_nib = nib_sr[DEPTH-1];

endmodule

// File: rtl/sa_ins_addr_sel.sv
// Picks one nibble of the station address for a given index.
// The bytes go from the most significant byte down, and within each byte
// the low nibble comes first.
// Assumes: NIB_W is half a byte; an index past the end gives zero.
module sa_ins_addr_sel #(
    parameter int NIB_W  = 4,
    parameter int ADDR_W = 48,
    localparam int NNIB  = ADDR_W / NIB_W,
    localparam int IDX_W = $clog2(NNIB)
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [IDX_W-1:0]  idx,
    output logic [NIB_W-1:0]  nib
);

    localparam int BYTE_W = 2 * NIB_W;

    logic [NIB_W-1:0] nib_arr [NNIB];

    // Place the nibbles in the order they are sent
    for (genvar g = 0; g < NNIB; g++) begin : g_nib
        localparam int LSB = ADDR_W - BYTE_W * (g / 2) - BYTE_W + NIB_W * (g % 2);
        assign nib_arr[g] = addr[LSB +: NIB_W];
    end

    // Select the nibble for the index
    always_comb begin
        nib = '0;
        if (int'(idx) < NNIB) begin
            nib = nib_arr[idx];
        end
    end

endmodule

// File: rtl/src_addr_inserter.sv
// Inserts the station address after the destination address of a nibble
// stream. Output is registered: one strobe of latency.
// Assumes: in insertion mode, at least NNIB idle strobes between frames;
// in_vld changes only on strobe cycles.
module src_addr_inserter
    import sa_ins_pkg::*;
#(
    parameter int NIB_W  = 4,
    parameter int ADDR_W = 48
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce,
    input  logic              ins_en,
    input  logic              cancel,
    input  logic [ADDR_W-1:0] station_addr,
    input  logic              in_vld,
    input  logic [NIB_W-1:0]  in_nib,
    output logic              out_vld,
    output logic [NIB_W-1:0]  out_nib
);

    localparam int NNIB  = ADDR_W / NIB_W;
    localparam int CNT_W = $clog2(NNIB);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(NNIB - 1);

    ins_state_t        st;
    logic [CNT_W-1:0]  cnt;
    logic [ADDR_W-1:0] addr_q;
    logic              dl_vld;
    logic [NIB_W-1:0]  dl_nib;
    logic [NIB_W-1:0]  addr_nib;

    // Holds the incoming stream back while the address is sent
    sa_ins_delay #(
        .NIB_W (NIB_W),
        .DEPTH (NNIB)
    ) u_delay (
        .clk   (clk),
        .rst_n (rst_n),
        .ce    (ce),
        .flush (cancel),
        .d_vld (in_vld),
        .d_nib (in_nib),
        .q_vld (dl_vld),
        .q_nib (dl_nib)
    );

    // Gives the address nibble for the current count
    sa_ins_addr_sel #(
        .NIB_W  (NIB_W),
        .ADDR_W (ADDR_W)
    ) u_sel (
        .addr (addr_q),
        .idx  (cnt),
        .nib  (addr_nib)
    );

    // Frame control and output register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st      <= ST_IDLE;
            cnt     <= '0;
            addr_q  <= '0;
            out_vld <= 1'b0;
            out_nib <= '0;
        end else if (cancel) begin
            st      <= ST_ABORT;
            cnt     <= '0;
            out_vld <= 1'b0;
        end else if (ce) begin
            unique case (st)
                ST_IDLE: begin
                    out_vld <= in_vld;
                    out_nib <= in_nib;
                    cnt     <= CNT_W'(1);
                    if (in_vld) begin
                        addr_q <= station_addr;
                        st     <= ins_en ? ST_DEST : ST_PASS;
                    end
                end
                ST_PASS: begin
                    out_vld <= in_vld;
                    out_nib <= in_nib;
                    if (!in_vld) begin
                        st <= ST_IDLE;
                    end
                end
                ST_DEST: begin
                    out_vld <= in_vld;
                    out_nib <= in_nib;
                    if (!in_vld) begin
                        st <= ST_IDLE;
                    end else if (cnt == CNT_LAST) begin
                        st  <= ST_SRC;
                        cnt <= '0;
                    end else begin
                        cnt <= cnt + CNT_W'(1);
                    end
                end
                ST_SRC: begin
                    out_vld <= 1'b1;
                    out_nib <= addr_nib;
                    if (cnt == CNT_LAST) begin
                        st <= ST_BODY;
                    end else begin
                        cnt <= cnt + CNT_W'(1);
                    end
                end
                ST_BODY: begin
                    out_vld <= dl_vld;
                    out_nib <= dl_nib;
                    if (!dl_vld) begin
                        st <= ST_IDLE;
                    end
                end
                ST_ABORT: begin
                    out_vld <= 1'b0;
                    if (!in_vld) begin
                        st <= ST_IDLE;
                    end
                end
                default: begin
                    st      <= ST_IDLE;
                    out_vld <= 1'b0;
                end
            endcase
        end
    end

endmodule

// File: rtl/sa_ins_checker.sv
// Protocol checks for the source address inserter, connected by bind.
// Assumes: ce is driven to a known value from time zero.
module sa_ins_checker #(
    parameter int NIB_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ce,
    input logic             cancel,
    input logic             out_vld,
    input logic [NIB_W-1:0] out_nib
);

    // R1: reset drives the output valid low
    assert_reset_idle_R1: assert property (@(posedge clk)
        !rst_n |=> !out_vld);

    // R6: with no strobe and no cancel, outputs hold
    assert_hold_no_strobe_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!ce && !cancel) |=> ($stable(out_vld) && $stable(out_nib)));

    // R6: a frame can only start on a strobe
    assert_start_on_strobe_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_vld) |-> $past(ce));

    // R9: cancel empties the output on the next edge
    assert_cancel_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        cancel |=> !out_vld);

endmodule

bind src_addr_inserter sa_ins_checker #(.NIB_W(NIB_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .ce      (ce),
    .cancel  (cancel),
    .out_vld (out_vld),
    .out_nib (out_nib)
);

// File: tb/src_addr_inserter_tb.sv
`timescale 1ns/1ps
module src_addr_inserter_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ce = 1'b0;
    logic        ins_en = 1'b0;
    logic        cancel = 1'b0;
    logic [47:0] station_addr = 48'h0;
    logic        in_vld = 1'b0;
    logic [3:0]  in_nib = 4'h0;
    logic        out_vld;
    logic [3:0]  out_nib;

    int tests = 0;
    int fails = 0;

    logic [3:0] cap [256];
    logic [3:0] expv [256];
    int  ncap, nexp, nruns, stall_bad;
    bit  prev_v, stall_on;

    localparam logic [47:0] MAC_A = 48'h1A2B_3C4D_5E6F;
    localparam logic [47:0] MAC_B = 48'hF0E1_D2C3_B4A5;

    always #2 clk = ~clk;

    src_addr_inserter u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .ce           (ce),
        .ins_en       (ins_en),
        .cancel       (cancel),
        .station_addr (station_addr),
        .in_vld       (in_vld),
        .in_nib       (in_nib),
        .out_vld      (out_vld),
        .out_nib      (out_nib)
    );

    function automatic logic [3:0] pat(int k);
        return 4'((k * 7 + k / 3 + 1) & 15);
    endfunction

    function automatic logic [3:0] mac_nib(logic [47:0] m, int j);
        int b = j / 2;
        return 4'((m >> (40 - 8 * b + 4 * (j % 2))) & 48'hF);
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp, string what);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // One strobe; capture the output after it; optionally idle one cycle
    task automatic step(logic v, logic [3:0] nb);
        logic ov;
        logic [3:0] on;
        in_vld = v;
        in_nib = nb;
        ce = 1'b1;
        @(negedge clk);
        ce = 1'b0;
        if (out_vld) begin
            cap[ncap] = out_nib;
            ncap++;
            if (!prev_v) nruns++;
        end
        prev_v = out_vld;
        if (stall_on) begin
            ov = out_vld;
            on = out_nib;
            @(negedge clk);
            if (out_vld !== ov || out_nib !== on) stall_bad++;
        end
    endtask

    task automatic clear_cap();
        ncap = 0; nruns = 0; prev_v = 0; stall_bad = 0;
    endtask

    task automatic send(int n, bit en, int flip_en_at, int flip_mac_at);
        clear_cap();
        ins_en = en;
        station_addr = MAC_A;
        for (int k = 0; k < n; k++) begin
            if (k == flip_en_at) ins_en = !en;
            if (k == flip_mac_at) station_addr = MAC_B;
            step(1'b1, pat(k));
        end
        for (int k = 0; k < 30; k++) step(1'b0, 4'h0);
        ins_en = en;
        station_addr = MAC_A;
    endtask

    task automatic build_exp(int n, bit en);
        nexp = 0;
        if (en && n >= 12) begin
            for (int k = 0; k < 12; k++) begin expv[nexp] = pat(k); nexp++; end
            for (int j = 0; j < 12; j++) begin expv[nexp] = mac_nib(MAC_A, j); nexp++; end
            for (int k = 12; k < n; k++) begin expv[nexp] = pat(k); nexp++; end
        end else begin
            for (int k = 0; k < n; k++) begin expv[nexp] = pat(k); nexp++; end
        end
    endtask

    task automatic check_range(string req, int lo, int hi);
        int bad = -1;
        for (int i = lo; i <= hi; i++) begin
            if (bad < 0 && cap[i] !== expv[i]) bad = i;
        end
        if (bad < 0) check(req, 0, 0, "range");
        else check(req, {28'h0, cap[bad]}, {28'h0, expv[bad]},
                   $sformatf("nibble %0d", bad));
    endtask

    task automatic check_frame(string req);
        check(req, 32'(ncap), 32'(nexp), "length");
        if (nexp > 0) check(req, 32'(nruns), 32'd1, "valid runs");
        if (ncap == nexp && nexp > 0) check_range(req, 0, nexp - 1);
    endtask

    task automatic t_reset();
        @(negedge clk);
        check("R1", {31'h0, out_vld}, 32'h0, "out_vld in reset");
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", {31'h0, out_vld}, 32'h0, "out_vld after reset");
    endtask

    task automatic t_pass();
        send(20, 1'b0, -1, -1);
        build_exp(20, 1'b0);
        check_frame("R2");
    endtask

    task automatic t_insert();
        send(30, 1'b1, -1, -1);
        build_exp(30, 1'b1);
        check("R5", 32'(ncap), 32'd42, "length");
        check("R5", 32'(nruns), 32'd1, "valid runs");
        if (ncap == 42) begin
            check_range("R3", 0, 11);
            check_range("R4", 12, 23);
            check_range("R5", 24, 41);
        end
    endtask

    task automatic t_exact12();
        send(12, 1'b1, -1, -1);
        build_exp(12, 1'b1);
        check_frame("R11");
    endtask

    task automatic t_runt();
        send(8, 1'b1, -1, -1);
        build_exp(8, 1'b1);
        check_frame("R10");
    endtask

    task automatic t_stall();
        stall_on = 1'b1;
        send(25, 1'b1, -1, -1);
        check("R6", 32'(stall_bad), 32'd0, "insert changes without strobe");
        build_exp(25, 1'b1);
        check_frame("R6");
        send(16, 1'b0, -1, -1);
        check("R6", 32'(stall_bad), 32'd0, "pass changes without strobe");
        stall_on = 1'b0;
    endtask

    task automatic t_en_flip();
        send(26, 1'b1, 5, -1);
        build_exp(26, 1'b1);
        check_frame("R7");
        send(20, 1'b0, 5, -1);
        build_exp(20, 1'b0);
        check_frame("R7");
    endtask

    task automatic t_mac_flip();
        send(28, 1'b1, -1, 3);
        build_exp(28, 1'b1);
        check_frame("R8");
    endtask

    task automatic t_cancel();
        int bad = 0;
        clear_cap();
        ins_en = 1'b1;
        station_addr = MAC_A;
        for (int k = 0; k < 15; k++) step(1'b1, pat(k));
        cancel = 1'b1;
        @(negedge clk);
        cancel = 1'b0;
        check("R9", {31'h0, out_vld}, 32'h0, "out_vld after cancel");
        for (int k = 15; k < 25; k++) begin
            step(1'b1, pat(k));
            if (out_vld) bad++;
        end
        check("R9", 32'(bad), 32'd0, "output while input ignored");
        for (int k = 0; k < 30; k++) step(1'b0, 4'h0);
        send(20, 1'b1, -1, -1);
        build_exp(20, 1'b1);
        check_frame("R9");
    endtask

    initial begin
        #(4 * 200000);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        stall_on = 1'b0;
        clear_cap();
        repeat (3) @(negedge clk);
        t_reset();
        repeat (3) @(negedge clk);
        t_pass();
        t_insert();
        t_exact12();
        t_runt();
        t_stall();
        t_en_flip();
        t_mac_flip();
        t_cancel();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule